// File: doc/BRIEF.md
# Interrupt Throttle and Mask Controller

This block gathers the interrupt causes of a network interface into one cause register and drives a single interrupt line to the host. A mask register selects which causes may raise the line. A programmable throttle interval, counted in units of 256 ns, sets how long the block waits between a new cause and the posting of the interrupt. A source can also ask for immediate posting, which skips the throttle wait.

Each cause request ORs its bits into the cause register. When the interval is zero, or the request carries the immediate flag, the block tries to post at once. Otherwise it starts the throttle timer, and a timer that is already counting keeps its original deadline. A post takes effect only if some cause is unmasked at that moment. A successful post sets the asserted flag and stops the timer. If the receive delay timer is armed at that point, the post also records the receive-timer cause and sends a cancel pulse to that timer. Mask writes go through the same decision, and they also lower the line when no cause is left unmasked. A read-to-clear strobe empties the register and drops the line.

Top module: `irq_throttle_ctrl`

## Requirements
- R1: After reset the cause register reads 0, the interrupt line is low and the receive-delay cancel pulse is low.
- R2: Cause register layout: bits [CAUSE_W-2:0] hold the causes and bit CAUSE_W-1 is the asserted flag, which always equals the interrupt line. A request ORs its bits into the causes, and they are visible the cycle after the request.
- R3: With the interval set to 0, a fresh request that leaves an unmasked cause raises the line the cycle after the request.
- R4: A request with the immediate flag posts the next cycle whatever the interval is, and it stops a running throttle timer so that the timer's old deadline has no effect.
- R5: With a nonzero interval I, a fresh non-immediate request arms an idle timer. The line rises I*U cycles after the arming edge, where U = floor(256 / CLK_PERIOD_NS), or 1 if the period is at least 256 ns.
- R6: A further fresh request while the timer is running does not restart it, so the deadline stays where the first request set it.
- R7: A non-immediate request whose bits are already all pending, or overlap pending bits, only ORs them in. It neither posts nor arms the timer.
- R8: A post only takes effect while the causes ANDed with the mask are nonzero. A masked cause is still recorded, but the line stays low.
- R9: A mask write that leaves an unmasked cause posts the next cycle when the interval is 0, and otherwise arms the timer if it is idle.
- R10: A mask write that leaves no unmasked cause lowers the line the next cycle (the causes are kept) and stops the throttle timer.
- R11: A successful post while the receive-delay-armed input is high sets cause bit RXT_BIT (bit 0 by default) and raises the cancel output for exactly one cycle, in the cycle the line rises.
- R12: A read-to-clear strobe leaves the cause register at 0 on the next cycle (apart from bits requested in the same cycle) and drops the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cause_req | input | CAUSE_W-1 | One-cycle cause request bits |
| cause_now | input | 1 | Post immediately, qualifies cause_req |
| mask_wr | input | 1 | Mask register write strobe |
| mask_wdata | input | CAUSE_W-1 | New mask value, 1 = cause enabled |
| itvl_wr | input | 1 | Throttle interval write strobe |
| itvl_wdata | input | ITVL_W | New interval in 256 ns units |
| cause_rd | input | 1 | Read-to-clear strobe for the cause register |
| rxdly_armed | input | 1 | Receive delay timer is running |
| irq | output | 1 | Interrupt line to the host |
| cause_q | output | CAUSE_W | Cause register contents, asserted flag on top |
| rxdly_cancel | output | 1 | One-cycle pulse that stops the receive delay timer |

## Verification
The assertions check on every cycle that requested bits appear in the register, that a read empties it, that the line never rises without an unmasked cause, that a mask write leaving nothing unmasked lowers the line, and that the cancel pulse only comes together with a post that recorded the receive-timer bit. They cannot check timing. The exact throttle deadline, the fact that a later request does not restart the timer, that an immediate post or an emptying mask write stops the timer, and that a duplicate request arms nothing are all shown only by the bench's directed scenarios. Those scenarios sample the line one cycle before and at the expected deadline, and they place the check so that a stale or restarted timer would move the rising edge where it can be seen.

// File: rtl/irqt_pkg.sv
// Shared definitions for the interrupt throttle controller.
// Assumes the clock period is given in whole nanoseconds.
package irqt_pkg;
    localparam int unsigned THROTTLE_UNIT_NS = 256;

    // Cycles per throttle unit, never below one.
    function automatic int unsigned unit_cycles(input int unsigned period_ns);
        if (period_ns >= THROTTLE_UNIT_NS || period_ns == 0)
            return 1;
        return THROTTLE_UNIT_NS / period_ns;
    endfunction

    // Command from the posting logic to the throttle timer.
    typedef enum logic [1:0] {
        TMR_HOLD = 2'd0,
        TMR_LOAD = 2'd1,
        TMR_STOP = 2'd2
    } tmr_act_e;
endpackage

// File: rtl/irqt_prescaler.sv
// Divides the clock down to one tick per throttle unit.
// Assumes restart and run come from the timer that owns it; restart
// realigns the unit boundary to the arming edge.
module irqt_prescaler #(
    parameter int unsigned UNIT = 51
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic tick
);
    localparam int unsigned PW = (UNIT > 1) ? $clog2(UNIT) : 1;
    localparam logic [PW-1:0] TOP = PW'(UNIT - 1);

    logic [PW-1:0] cnt;

    // Count down through one unit, reload on restart or on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= TOP;
        else if (restart)
            cnt <= TOP;
        else if (run)
            cnt <= (cnt == '0) ? TOP : cnt - 1'b1;
    end

    assign tick = run && (cnt == '0);
endmodule

// File: rtl/irqt_throttle_timer.sv
// One-shot throttle timer counting whole units of 256 ns.
// Assumes LOAD is only issued with a nonzero interval and while idle;
// fire is high for one cycle at the end of the last unit.
module irqt_throttle_timer
    import irqt_pkg::*;
#(
    parameter int unsigned ITVL_W = 16,
    parameter int unsigned UNIT   = 51
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tmr_act_e          act,
    input  logic [ITVL_W-1:0] itvl,
    output logic              running,
    output logic              fire
);
    localparam logic [ITVL_W-1:0] LAST = ITVL_W'(1);

    logic [ITVL_W-1:0] units;
    logic              tick;

    irqt_prescaler #(.UNIT(UNIT)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (act == TMR_LOAD),
        .run     (running),
        .tick    (tick)
    );

    assign fire = running && tick && (units == LAST);

    // Track remaining units and the running state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            units   <= '0;
        end else begin
            case (act)
                TMR_STOP: running <= 1'b0;
                TMR_LOAD: begin
                    running <= 1'b1;
                    units   <= itvl;
                end
                default: begin
                    if (fire)
                        running <= 1'b0;
                    else if (tick)
                        units <= units - 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/irqt_cause_reg.sv
// Cause register, asserted flag and mask register.
// Exposes the next pending causes and next mask so the posting logic
// judges a post against the state the edge will store.
module irqt_cause_reg #(
    parameter int unsigned N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cause_rd,
    input  logic [N-1:0] cause_req,
    input  logic [N-1:0] extra_set,
    input  logic         set_flag,
    input  logic         clr_flag,
    input  logic         mask_wr,
    input  logic [N-1:0] mask_wdata,
    output logic [N-1:0] pend_nx,
    output logic [N-1:0] mask_nx,
    output logic         dup_hit,
    output logic [N-1:0] cause_lo,
    output logic [N-1:0] mask_q,
    output logic         flag_q
);
    logic [N-1:0] pend_base;

    // Pending causes after a read-to-clear, then with new requests.
    always_comb begin
        pend_base = cause_rd ? '0 : cause_lo;
        pend_nx   = pend_base | cause_req;
        mask_nx   = mask_wr ? mask_wdata : mask_q;
        dup_hit   = |(cause_req & pend_base);
    end

    // Store causes, mask and the asserted flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_lo <= '0;
            mask_q   <= '0;
            flag_q   <= 1'b0;
        end else begin
            cause_lo <= pend_nx | extra_set;
            mask_q   <= mask_nx;
            if (set_flag)
                flag_q <= 1'b1;
            else if (clr_flag)
                flag_q <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_throttle_ctrl.sv
// Top of the interrupt throttle and mask controller.
// Decides each cycle whether to post, arm or stop the throttle timer
// from requests, mask writes and timer expiry. Assumes all strobes are
// single-cycle and synchronous to clk. Interval writes apply next cycle.
module irq_throttle_ctrl
    import irqt_pkg::*;
#(
    parameter int unsigned CAUSE_W       = 8,
    parameter int unsigned ITVL_W        = 16,
    parameter int unsigned CLK_PERIOD_NS = 5,
    parameter int unsigned RXT_BIT       = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CAUSE_W-2:0] cause_req,
    input  logic               cause_now,
    input  logic               mask_wr,
    input  logic [CAUSE_W-2:0] mask_wdata,
    input  logic               itvl_wr,
    input  logic [ITVL_W-1:0]  itvl_wdata,
    input  logic               cause_rd,
    input  logic               rxdly_armed,
    output logic               irq,
    output logic [CAUSE_W-1:0] cause_q,
    output logic               rxdly_cancel
);
    localparam int unsigned N    = CAUSE_W - 1;
    localparam int unsigned UNIT = unit_cycles(CLK_PERIOD_NS);
    localparam logic [N-1:0] RXT_M = N'(1) << RXT_BIT;

    logic [ITVL_W-1:0] itvl_q;
    logic [N-1:0]      pend_nx, mask_nx, cause_lo, mask_q, extra_set;
    logic              dup_hit, flag_q, tmr_running, tmr_fire;
    logic              req_fresh, itvl_zero, hit, now_path;
    logic              mask_post, mask_arm, mask_drop, post_ok, arm_try;
    logic              cancel_q;
    tmr_act_e          act;

    irqt_cause_reg #(.N(N)) u_cause (
        .clk        (clk),
        .rst_n      (rst_n),
        .cause_rd   (cause_rd),
        .cause_req  (cause_req),
        .extra_set  (extra_set),
        .set_flag   (post_ok),
        .clr_flag   (cause_rd || mask_drop),
        .mask_wr    (mask_wr),
        .mask_wdata (mask_wdata),
        .pend_nx    (pend_nx),
        .mask_nx    (mask_nx),
        .dup_hit    (dup_hit),
        .cause_lo   (cause_lo),
        .mask_q     (mask_q),
        .flag_q     (flag_q)
    );

    irqt_throttle_timer #(.ITVL_W(ITVL_W), .UNIT(UNIT)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .act     (act),
        .itvl    (itvl_q),
        .running (tmr_running),
        .fire    (tmr_fire)
    );

    // Posting decision for this cycle.
    always_comb begin
        req_fresh = (|cause_req) && !(dup_hit && !cause_now);
        itvl_zero = (itvl_q == '0);
        hit       = |(pend_nx & mask_nx);
        now_path  = req_fresh && (itvl_zero || cause_now);
        mask_post = mask_wr && hit && itvl_zero;
        mask_arm  = mask_wr && hit && !itvl_zero;
        mask_drop = mask_wr && !hit;
        post_ok   = (now_path || mask_post || tmr_fire) && hit;
        arm_try   = (req_fresh && !itvl_zero && !cause_now) || mask_arm;
        extra_set = (post_ok && rxdly_armed) ? RXT_M : '0;
        if (post_ok || now_path || mask_drop)
            act = TMR_STOP;
        else if (arm_try && !tmr_running)
            act = TMR_LOAD;
        else
            act = TMR_HOLD;
    end

    // Interval register and registered cancel pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            itvl_q   <= '0;
            cancel_q <= 1'b0;
        end else begin
            if (itvl_wr)
                itvl_q <= itvl_wdata;
            cancel_q <= post_ok && rxdly_armed;
        end
    end

    assign irq          = flag_q;
    assign cause_q      = {flag_q, cause_lo};
    assign rxdly_cancel = cancel_q;
endmodule

// File: rtl/irqt_checker.sv
// Cycle-by-cycle properties of the interrupt throttle controller,
// bound to the top. Observes ports plus the stored mask.
module irqt_checker #(
    parameter int unsigned CAUSE_W = 8,
    parameter int unsigned RXT_BIT = 0
) (
    input logic               clk,
    input logic               rst_n,
    input logic [CAUSE_W-2:0] cause_req,
    input logic               cause_rd,
    input logic               mask_wr,
    input logic [CAUSE_W-2:0] mask_wdata,
    input logic               irq,
    input logic [CAUSE_W-1:0] cause_q,
    input logic               rxdly_cancel,
    input logic [CAUSE_W-2:0] mask_q
);
    localparam int unsigned N = CAUSE_W - 1;
    localparam logic [N-1:0] RXT_M = N'(1) << RXT_BIT;

    // Requested bits are present on the next cycle.
    assert_req_recorded_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|cause_req) |=> ((cause_q[N-1:0] & $past(cause_req)) == $past(cause_req)));

    // Read-to-clear empties the causes except the receive-timer fold.
    assert_read_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_rd && cause_req == '0) |=> ((cause_q[N-1:0] & ~RXT_M) == '0));

    // The line only rises with an unmasked cause pending.
    assert_rise_unmasked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (|(cause_q[N-1:0] & mask_q)));

    // An emptying mask write lowers the line.
    assert_mask_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_wr && !cause_rd && cause_req == '0 &&
         (cause_q[N-1:0] & mask_wdata) == '0) |=> !irq);

    // Cancel pulse only with a post that recorded the receive-timer bit.
    assert_cancel_with_post_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rxdly_cancel |-> (irq && cause_q[RXT_BIT]));

    // Cancel is a single-cycle pulse.
    assert_cancel_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rxdly_cancel |=> !rxdly_cancel);
endmodule

bind irq_throttle_ctrl irqt_checker #(.CAUSE_W(CAUSE_W), .RXT_BIT(RXT_BIT)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cause_req    (cause_req),
    .cause_rd     (cause_rd),
    .mask_wr      (mask_wr),
    .mask_wdata   (mask_wdata),
    .irq          (irq),
    .cause_q      (cause_q),
    .rxdly_cancel (rxdly_cancel),
    .mask_q       (mask_q)
);

// File: tb/irq_throttle_ctrl_tb.sv
// Directed bench: one task per scenario, inputs driven and outputs
// sampled on the falling edge.
module irq_throttle_ctrl_tb;
    localparam int PERIOD_NS = 5;
    localparam int UNIT      = 256 / PERIOD_NS;
    localparam int WIN       = 2 * UNIT;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  cause_req = '0;
    logic        cause_now = 1'b0;
    logic        mask_wr = 1'b0;
    logic [6:0]  mask_wdata = '0;
    logic        itvl_wr = 1'b0;
    logic [15:0] itvl_wdata = '0;
    logic        cause_rd = 1'b0;
    logic        rxdly_armed = 1'b0;
    logic        irq;
    logic [7:0]  cause_q;
    logic        rxdly_cancel;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    irq_throttle_ctrl #(.CAUSE_W(8), .ITVL_W(16), .CLK_PERIOD_NS(PERIOD_NS), .RXT_BIT(0)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cause_req    (cause_req),
        .cause_now    (cause_now),
        .mask_wr      (mask_wr),
        .mask_wdata   (mask_wdata),
        .itvl_wr      (itvl_wr),
        .itvl_wdata   (itvl_wdata),
        .cause_rd     (cause_rd),
        .rxdly_armed  (rxdly_armed),
        .irq          (irq),
        .cause_q      (cause_q),
        .rxdly_cancel (rxdly_cancel)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic req(input logic [6:0] bits, input logic now);
        cause_req = bits;
        cause_now = now;
        @(negedge clk);
        cause_req = '0;
        cause_now = 1'b0;
    endtask

    task automatic wr_mask(input logic [6:0] m);
        mask_wr = 1'b1;
        mask_wdata = m;
        @(negedge clk);
        mask_wr = 1'b0;
    endtask

    task automatic wr_itvl(input logic [15:0] v);
        itvl_wr = 1'b1;
        itvl_wdata = v;
        @(negedge clk);
        itvl_wr = 1'b0;
    endtask

    task automatic rd();
        cause_rd = 1'b1;
        @(negedge clk);
        cause_rd = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 cause_q", cause_q, 8'h00);
        check("R1 irq", irq, 1'b0);
        check("R1 rxdly_cancel", rxdly_cancel, 1'b0);
    endtask

    task automatic t_basic();
        do_reset();
        wr_mask(7'h06);
        req(7'h02, 1'b0);
        check("R3 irq after zero-interval request", irq, 1'b1);
        check("R2 cause_q layout", cause_q, 8'h82);
        req(7'h10, 1'b0);
        check("R2 masked bit ORed in", cause_q, 8'h92);
        rd();
        check("R12 cause_q cleared", cause_q, 8'h00);
        check("R12 irq dropped", irq, 1'b0);
    endtask

    task automatic t_masked();
        do_reset();
        wr_mask(7'h02);
        req(7'h08, 1'b0);
        check("R8 masked cause keeps irq low", irq, 1'b0);
        check("R8 masked cause recorded", cause_q, 8'h08);
    endtask

    task automatic t_throttle();
        do_reset();
        wr_mask(7'h06);
        wr_itvl(16'd2);
        req(7'h02, 1'b0);
        idle(40);
        req(7'h04, 1'b0);
        idle(WIN - 1 - 41);
        check("R5 irq low one cycle before deadline", irq, 1'b0);
        idle(1);
        check("R6 irq at first deadline, not restarted", irq, 1'b1);
        check("R5 cause_q at deadline", cause_q, 8'h86);
    endtask

    task automatic t_imm_cancel();
        do_reset();
        wr_mask(7'h06);
        wr_itvl(16'd2);
        req(7'h02, 1'b0);
        idle(10);
        req(7'h04, 1'b1);
        check("R4 immediate post", irq, 1'b1);
        rd();
        check("R12 read clears after immediate post", cause_q, 8'h00);
        req(7'h02, 1'b0);
        idle(WIN + 1 - 13);
        check("R4 old deadline cancelled", irq, 1'b0);
        idle(11);
        check("R5 new timer not yet expired", irq, 1'b0);
        idle(1);
        check("R5 new timer expiry", irq, 1'b1);
    endtask

    task automatic t_dup();
        do_reset();
        wr_itvl(16'd2);
        req(7'h02, 1'b1);
        check("R8 immediate but masked", irq, 1'b0);
        check("R8 masked immediate recorded", cause_q, 8'h02);
        req(7'h02, 1'b0);
        idle(40);
        wr_mask(7'h02);
        idle(WIN - 1);
        check("R7 duplicate did not arm timer", irq, 1'b0);
        idle(1);
        check("R9 mask write armed timer", irq, 1'b1);
    endtask

    task automatic t_mask();
        do_reset();
        req(7'h04, 1'b0);
        check("R8 no post with empty mask", irq, 1'b0);
        wr_mask(7'h04);
        check("R9 zero-interval mask write posts", irq, 1'b1);
        wr_mask(7'h00);
        check("R10 emptying mask drops irq", irq, 1'b0);
        check("R10 causes kept", cause_q, 8'h04);
        wr_itvl(16'd2);
        wr_mask(7'h04);
        check("R9 nonzero interval waits", irq, 1'b0);
        idle(10);
        wr_mask(7'h00);
        idle(10);
        wr_mask(7'h04);
        idle(WIN + 1 - 22);
        check("R10 timer stopped by emptying mask", irq, 1'b0);
        idle(20);
        check("R10 rearmed timer not yet expired", irq, 1'b0);
        idle(1);
        check("R9 rearmed timer expiry", irq, 1'b1);
    endtask

    task automatic t_rxdly();
        do_reset();
        wr_mask(7'h02);
        rxdly_armed = 1'b1;
        req(7'h02, 1'b0);
        rxdly_armed = 1'b0;
        check("R11 irq", irq, 1'b1);
        check("R11 cancel pulse", rxdly_cancel, 1'b1);
        check("R11 receive-timer bit", cause_q, 8'h83);
        idle(1);
        check("R11 cancel one cycle", rxdly_cancel, 1'b0);
    endtask

    initial begin
        idle(1);
        t_reset();
        t_basic();
        t_masked();
        t_throttle();
        t_imm_cancel();
        t_dup();
        t_mask();
        t_rxdly();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule